// File: doc/BRIEF.md
# LPC Firmware Window Address Remapper

This block sits between an LPC target front end and an on-chip AHB master. For each firmware-space cycle it takes the 32-bit address and checks whether the cycle falls inside a programmable window. The check uses only the upper half of the address. When the cycle hits, the block builds the upper half of the AHB address bit by bit from a remap base and the incoming address. The lower half passes through unchanged. The block then issues the access with its size and direction. When the cycle misses, the block stays silent so that another target can claim it.

Two 32-bit configuration words control the window. Word A holds the remap base in [31:16] and the match base in [15:0]. Word B holds the remap mask in [31:16] and the match don't-care mask in [15:0]. The match side and the remap side each have their own per-bit mask, so a window of any power-of-two size can be placed at any aligned LPC location and at any aligned AHB location.

A small state machine sequences one access at a time through three states:
- `ST_IDLE`: waits for a request. Transition `accept_hit` goes to `ST_ISSUE`, `accept_miss` stays in `ST_IDLE`, and `no_req` stays in `ST_IDLE`.
- `ST_ISSUE`: holds the AHB request. Transition `ahb_wait` stays in `ST_ISSUE`, and `ahb_finish` goes to `ST_RESP`.
- `ST_RESP`: presents the response for one cycle. Transition `resp_done` returns to `ST_IDLE`.

Top module: `lpc_fw_remap`

## Requirements
- R1: After reset, both configuration words are zero, `req_ready` is 1, and `ahb_req` and `rsp_valid` are 0. While both words are zero, every cycle misses.
- R2: A configuration write with `cfg_sel`=0 loads word A, and one with `cfg_sel`=1 loads word B. The field layout is as given above, and the new value applies from the next cycle.
- R3: A cycle hits when every bit of `req_addr[31:16]` whose don't-care bit is 0 equals the same bit of the match base. A hit is accepted in `ST_IDLE` and raises `ahb_req` in the following cycle.
- R4: For a hit, bit n of `ahb_addr`, for n from 16 to 31, equals remap-base bit n when remap-mask bit n is 1. Otherwise it equals `req_addr` bit n.
- R5: `ahb_addr[15:0]` equals `req_addr[15:0]` of the accepted cycle.
- R6: `ahb_size` and `ahb_write` equal the `req_size` and `req_write` of the accepted cycle. `req_size` 0 means 1 byte and 1 means 4 bytes.
- R7: A miss produces no `ahb_req` and no `rsp_valid`, and `req_ready` remains 1.
- R8: `ahb_req`, `ahb_addr`, `ahb_size`, `ahb_write` and `ahb_wdata` hold steady until a cycle in which `ahb_done` is 1. In the cycle after that, `rsp_valid` is 1 for exactly one cycle and `ahb_req` is 0.
- R9: On a byte read, `rsp_rdata` holds the `ahb_rdata` lane selected by `addr[1:0]` (lane k is bits [8k+7:8k]) in bits [7:0], with zeros above. On a word read, `rsp_rdata` is the whole `ahb_rdata` word. `rsp_rdata` is 0 on writes.
- R10: On a byte write, `ahb_wdata` carries `req_wdata[7:0]` in lane `addr[1:0]` and zeros elsewhere. On a word write, it carries `req_wdata` unchanged.
- R11: With A=0x30000E00 and B=0xFE0001FF, LPC 0x0E000000–0x0FFFFFFF maps onto AHB 0x30000000–0x31FFFFFF. With A=0x3000FCE0 and B=0xFFE0001F, LPC 0xFCE00000–0xFCFFFFFF maps onto AHB 0x30000000–0x301FFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects word A, 1 selects word B |
| cfg_wdata | input | 32 | Configuration write value |
| req_valid | input | 1 | Firmware cycle request |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 1 | 0 = byte, 1 = word |
| req_addr | input | 32 | LPC firmware address |
| req_wdata | input | 32 | Write data; a byte write uses bits [7:0] |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 32 | Read data, lane-aligned as in R9 |
| ahb_req | output | 1 | AHB access request, held until done |
| ahb_write | output | 1 | AHB access direction |
| ahb_size | output | 1 | AHB access size, same encoding as `req_size` |
| ahb_addr | output | 32 | Translated AHB address |
| ahb_wdata | output | 32 | Lane-placed write data |
| ahb_done | input | 1 | AHB access complete |
| ahb_rdata | input | 32 | AHB read data, valid with `ahb_done` |

## Verification
The embedded properties assume the following about the block's inputs:
- `req_valid` is sampled only while `req_ready` is high.
- `ahb_done` arrives only while `ahb_req` is high.
- `ahb_rdata` is meaningful only in the cycle of `ahb_done`.

The directed stimulus keeps within these assumptions. It presents each request for exactly one cycle while the block is idle. It raises `ahb_done` only after it has observed `ahb_req`, and it holds `ahb_done` low for a while first so that the hold behaviour is exercised. It changes the configuration only between accesses.

// File: rtl/lpcw_pkg.sv
package lpcw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_RESP  = 2'd2
    } lpcw_state_e;

    typedef enum logic {
        SZ_BYTE = 1'b0,
        SZ_WORD = 1'b1
    } lpcw_size_e;
endpackage

// File: rtl/lpcw_cfg_regs.sv
module lpcw_cfg_regs #(
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [2*HALF_W-1:0] wr_data,
    output logic [HALF_W-1:0] remap_base,
    output logic [HALF_W-1:0] match_base,
    output logic [HALF_W-1:0] remap_mask,
    output logic [HALF_W-1:0] care_off,
    output logic              any_set
);
    logic [2*HALF_W-1:0] word_a;
    logic [2*HALF_W-1:0] word_b;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_a <= '0;
            word_b <= '0;
        end else if (wr_en) begin
            if (wr_sel) word_b <= wr_data;
            else        word_a <= wr_data;
        end
    end

    assign remap_base = word_a[2*HALF_W-1:HALF_W];
    assign match_base = word_a[HALF_W-1:0];
    assign remap_mask = word_b[2*HALF_W-1:HALF_W];
    assign care_off   = word_b[HALF_W-1:0];
    assign any_set    = |{word_a, word_b};
endmodule

// File: rtl/lpcw_xlate.sv
module lpcw_xlate #(
    parameter int HALF_W = 16
) (
    input  logic [HALF_W-1:0] addr_hi,
    input  logic [HALF_W-1:0] remap_base,
    input  logic [HALF_W-1:0] match_base,
    input  logic [HALF_W-1:0] remap_mask,
    input  logic [HALF_W-1:0] care_off,
    input  logic              enable,
    output logic              hit,
    output logic [HALF_W-1:0] out_hi
);
    logic [HALF_W-1:0] bit_ok;

    for (genvar i = 0; i < HALF_W; i++) begin : g_bit
        assign bit_ok[i] = care_off[i] | (addr_hi[i] == match_base[i]);
        assign out_hi[i] = remap_mask[i] ? remap_base[i] : addr_hi[i];
    end

    assign hit = enable & (&bit_ok);
endmodule

// File: rtl/lpcw_lanes.sv
module lpcw_lanes #(
    parameter int DATA_W = 32
) (
    input  logic                      size_word,
    input  logic [$clog2(DATA_W/8)-1:0] lane,
    input  logic                      is_write,
    input  logic [DATA_W-1:0]         wr_raw,
    input  logic [DATA_W-1:0]         rd_raw,
    output logic [DATA_W-1:0]         wr_placed,
    output logic [DATA_W-1:0]         rd_aligned
);
    localparam int LANES = DATA_W / 8;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign wr_placed[8*k +: 8] = size_word ? wr_raw[8*k +: 8]
                                   : ((lane == k) ? wr_raw[7:0] : 8'h00);
    end

    always_comb begin
        rd_aligned = '0;
        if (!is_write) begin
            if (size_word) rd_aligned = rd_raw;
            else           rd_aligned[7:0] = rd_raw[8*lane +: 8];
        end
    end
endmodule

// File: rtl/lpc_fw_remap.sv
module lpc_fw_remap #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              ahb_req,
    output logic              ahb_write,
    output logic              ahb_size,
    output logic [ADDR_W-1:0] ahb_addr,
    output logic [DATA_W-1:0] ahb_wdata,
    input  logic              ahb_done,
    input  logic [DATA_W-1:0] ahb_rdata
);
    import lpcw_pkg::*;

    localparam int HALF_W = ADDR_W / 2;
    localparam int LANE_W = $clog2(DATA_W / 8);

    lpcw_state_e       state, state_nx;
    logic [HALF_W-1:0] remap_base, match_base, remap_mask, care_off;
    logic              cfg_any, win_hit, accept;
    logic [HALF_W-1:0] xl_hi;
    logic [DATA_W-1:0] wdata_q, rd_aligned;

    lpcw_cfg_regs #(.HALF_W(HALF_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_sel(cfg_sel),
        .wr_data(cfg_wdata), .remap_base(remap_base), .match_base(match_base),
        .remap_mask(remap_mask), .care_off(care_off), .any_set(cfg_any)
    );

    lpcw_xlate #(.HALF_W(HALF_W)) u_xlate (
        .addr_hi(req_addr[ADDR_W-1:HALF_W]), .remap_base(remap_base),
        .match_base(match_base), .remap_mask(remap_mask), .care_off(care_off),
        .enable(cfg_any), .hit(win_hit), .out_hi(xl_hi)
    );

    lpcw_lanes #(.DATA_W(DATA_W)) u_lanes (
        .size_word(ahb_size), .lane(ahb_addr[LANE_W-1:0]), .is_write(ahb_write),
        .wr_raw(wdata_q), .rd_raw(ahb_rdata),
        .wr_placed(ahb_wdata), .rd_aligned(rd_aligned)
    );

    assign accept = req_valid && (state == ST_IDLE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (accept && win_hit) state_nx = ST_ISSUE;
            ST_ISSUE: if (ahb_done)          state_nx = ST_RESP;
            ST_RESP:                          state_nx = ST_IDLE;
            default:                          state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        ahb_req   = 1'b0;
        rsp_valid = 1'b0;
        unique case (state)
            ST_IDLE:  req_ready = 1'b1;
            ST_ISSUE: ahb_req   = 1'b1;
            ST_RESP:  rsp_valid = 1'b1;
            default:  req_ready = 1'b0;
        endcase
    end

    // access capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ahb_addr  <= '0;
            ahb_write <= 1'b0;
            ahb_size  <= 1'b0;
            wdata_q   <= '0;
            rsp_rdata <= '0;
        end else begin
            if (accept && win_hit) begin
                ahb_addr  <= {xl_hi, req_addr[HALF_W-1:0]};
                ahb_write <= req_write;
                ahb_size  <= req_size;
                wdata_q   <= req_wdata;
            end
            if (state == ST_ISSUE && ahb_done) rsp_rdata <= rd_aligned;
        end
    end

    p_miss_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !win_hit) |=> (!ahb_req && !rsp_valid && req_ready));
    p_hit_issues_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && win_hit) |=> ahb_req);
    p_low_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && win_hit) |=> (ahb_addr[HALF_W-1:0] == $past(req_addr[HALF_W-1:0])));
    p_size_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && win_hit) |=> (ahb_size == $past(req_size) && ahb_write == $past(req_write)));
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ahb_req && !ahb_done) |=> (ahb_req && $stable(ahb_addr) && $stable(ahb_wdata)
                                    && $stable(ahb_size) && $stable(ahb_write)));
    p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    p_rsp_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ahb_req && ahb_done) |=> (rsp_valid && !ahb_req));
    p_one_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_ready, ahb_req, rsp_valid}));
endmodule

// File: tb/tb_lpc_fw_remap.sv
module tb_lpc_fw_remap;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_size = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        req_ready, rsp_valid, ahb_req, ahb_write, ahb_size;
    logic [31:0] rsp_rdata, ahb_addr, ahb_wdata;
    logic        ahb_done = 1'b0;
    logic [31:0] ahb_rdata = '0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lpc_fw_remap dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .ahb_req(ahb_req), .ahb_write(ahb_write), .ahb_size(ahb_size),
        .ahb_addr(ahb_addr), .ahb_wdata(ahb_wdata), .ahb_done(ahb_done),
        .ahb_rdata(ahb_rdata)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic sel, input logic [31:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // A hit: check the issued access, stall, complete, check the response.
    task automatic access_hit(input string tag, input logic wr, input logic sz,
                              input logic [31:0] la, input logic [31:0] wd,
                              input logic [31:0] exp_aa, input logic [31:0] exp_wd,
                              input logic [31:0] rd, input logic [31:0] exp_rd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = la; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        check(ahb_req == 1'b1, {tag, " R3 ahb_req"}, 32'(ahb_req), 32'd1);
        check(ahb_addr == exp_aa, {tag, " R4/R5/R11 ahb_addr"}, ahb_addr, exp_aa);
        check(ahb_size == sz && ahb_write == wr, {tag, " R6 size/dir"},
              {30'd0, ahb_size, ahb_write}, {30'd0, sz, wr});
        if (wr) check(ahb_wdata == exp_wd, {tag, " R10 ahb_wdata"}, ahb_wdata, exp_wd);
        @(negedge clk);
        @(negedge clk);
        check(ahb_req && ahb_addr == exp_aa && rsp_valid == 1'b0, {tag, " R8 hold"},
              ahb_addr, exp_aa);
        ahb_done = 1'b1; ahb_rdata = rd;
        @(negedge clk);
        ahb_done = 1'b0; ahb_rdata = 32'hDEAD_BEEF;
        check(rsp_valid && !ahb_req, {tag, " R8 rsp_valid"}, 32'(rsp_valid), 32'd1);
        check(rsp_rdata == exp_rd, {tag, " R9 rsp_rdata"}, rsp_rdata, exp_rd);
        @(negedge clk);
        check(!rsp_valid && req_ready, {tag, " R8 one-cycle rsp"}, 32'(rsp_valid), 32'd0);
    endtask

    task automatic access_miss(input string tag, input logic [31:0] la);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_size = 1'b1; req_addr = la;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            check(!ahb_req && !rsp_valid && req_ready, {tag, " R7 miss silent"},
                  {29'd0, ahb_req, rsp_valid, req_ready}, 32'd1);
            @(negedge clk);
        end
    endtask

    task automatic test_reset();
        check(req_ready && !ahb_req && !rsp_valid, "R1 reset outputs",
              {29'd0, req_ready, ahb_req, rsp_valid}, 32'd4);
        access_miss("R1 zero cfg 0x00001234", 32'h0000_1234);
        access_miss("R1 zero cfg 0x00000000", 32'h0000_0000);
    endtask

    task automatic test_window_a();
        cfg_write(1'b0, 32'h3000_0E00);   // R2 word A
        cfg_write(1'b1, 32'hFE00_01FF);   // R2 word B
        access_hit("R11 winA low word read", 1'b0, 1'b1, 32'h0E00_0000, 32'h0,
                   32'h3000_0000, 32'h0, 32'hAABB_CCDD, 32'hAABB_CCDD);
        access_hit("R11 winA top byte read lane1", 1'b0, 1'b0, 32'h0FFF_FFFD, 32'h0,
                   32'h31FF_FFFD, 32'h0, 32'hAABB_CCDD, 32'h0000_00CC);
        access_hit("R9 winA byte read lane3", 1'b0, 1'b0, 32'h0E12_3457, 32'h0,
                   32'h3012_3457, 32'h0, 32'h8877_6655, 32'h0000_0088);
        access_miss("R3 winA above", 32'h1000_0000);
        access_miss("R3 winA below", 32'h0DFF_FFFF);
    endtask

    task automatic test_window_b();
        cfg_write(1'b1, 32'hFFE0_001F);   // R2 only word B changes
        // word A still 0x30000E00: match base 0x0E00, so 0xFCE0xxxx misses
        access_miss("R2 word A unchanged", 32'hFCE0_0000);
        cfg_write(1'b0, 32'h3000_FCE0);
        access_hit("R11 winB word write", 1'b1, 1'b1, 32'hFCE0_0004, 32'h1122_3344,
                   32'h3000_0004, 32'h1122_3344, 32'h0, 32'h0);
        access_hit("R10 winB byte write lane3", 1'b1, 1'b0, 32'hFCFF_FFFF, 32'hFFFF_FF5A,
                   32'h301F_FFFF, 32'h5A00_0000, 32'h0, 32'h0);
        access_hit("R10 winB byte write lane0", 1'b1, 1'b0, 32'hFCE1_0000, 32'h0000_00C3,
                   32'h3001_0000, 32'h0000_00C3, 32'h0, 32'h0);
        access_miss("R3 winB above", 32'hFD00_0000);
    endtask

    task automatic test_passthrough();
        // R4: remap mask 0 keeps every upper bit from the LPC address
        cfg_write(1'b0, 32'h3000_1200);
        cfg_write(1'b1, 32'h0000_00FF);
        access_hit("R4 mask zero identity", 1'b0, 1'b1, 32'h12AB_CDE0, 32'h0,
                   32'h12AB_CDE0, 32'h0, 32'h0102_0304, 32'h0102_0304);
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                errors++;
                $display("FAIL watchdog actual=%0d expected<=20000", cycles);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_window_a();
        test_window_b();
        test_passthrough();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule